// File: doc/BRIEF.md
# Tick-Driven Real-Time-Clock Interrupt Emulator

This block produces real-time-clock style interrupt flags from a free-running counter, not from a dedicated clock chip. It runs a comparator against the counter. Each time the counter reaches the comparator, one base tick is serviced. The base tick rate is 64 Hz, which is `TICK_DELTA` counter steps. On every tick the block looks at the current hours, minutes and seconds, and it can raise up to three flags:

- **update**: the seconds field has changed since the last tick.
- **alarm**: the time of day equals a programmed alarm time.
- **periodic**: a programmable rate, given as a power of two from 2 Hz to 8192 Hz.

Periodic rates at or below 64 Hz are made by counting base ticks. Faster rates shorten the comparator interval.

If the counter has run past one or more comparator values before a tick is serviced, the block steps its comparator forward once per clock cycle until the comparator is ahead of the counter again. It reports how many steps were lost, and it adds them to the periodic count. A flagged tick sends out a one-cycle pulse together with a held flag word.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset `irq` is 0, `flags` is 0 and `lost` is 0.
- R2: When any enable becomes set while none was set, the comparator is loaded with counter plus one interval. A tick is serviced in the cycle the counter reaches the comparator, and its pulse follows two clock edges after that. Ticks then repeat every interval.
- R3: The update flag (`flags[4]`) is raised on a tick whose seconds differ from those seen at the previous serviced tick. It is never raised on the first tick after update enable is set.
- R4: The alarm flag (`flags[5]`) is raised on a tick where hours, minutes and seconds all equal the alarm fields, and not otherwise.
- R5: With `per_log2` = k ≤ 6, the periodic flag (`flags[6]`) is raised once every 2^(6-k) base ticks, using interval `TICK_DELTA`.
- R6: With k > 6, the interval becomes `TICK_DELTA >> (k-6)` and the periodic flag is raised on every tick.
- R7: When the counter is found past the comparator after the first advance, the comparator is stepped by one interval per cycle until it is not behind. Each of these extra steps is a lost tick. `lost` shows the lost count of the latest flagged tick.
- R8: When periodic mode is on, lost ticks are added to the periodic tick count before it is compared with the limit.
- R9: A flag word has bit 7 (summary) set, bits 15:8 equal to 1, source flags in bits 6:4 (periodic, alarm, update), and bits 3:0 zero.
- R10: While all three enables are clear the timer channel is idle and no pulse is produced.
- R11: Setting update enable from off to on makes the remembered seconds invalid.
- R12: The periodic tick count returns to zero whenever the periodic flag is raised.
- R13: `irq` is a one-cycle pulse. `flags` and `lost` hold their values until the next flagged tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Free-running counter value |
| sec_i | input | 6 | Current seconds |
| min_i | input | 6 | Current minutes |
| hr_i | input | 5 | Current hours |
| upd_en | input | 1 | Update source enable |
| alm_en | input | 1 | Alarm source enable |
| per_en | input | 1 | Periodic source enable |
| alm_sec | input | 6 | Alarm seconds |
| alm_min | input | 6 | Alarm minutes |
| alm_hr | input | 5 | Alarm hours |
| per_log2 | input | 4 | Periodic rate as log2 of Hz (1..13) |
| irq | output | 1 | One-cycle interrupt pulse |
| flags | output | 16 | Held flag word |
| lost | output | LW | Lost ticks of the latest flagged tick |

## Verification
On a single tick, the alarm flag and the periodic flag can both be raised in the same cycle. The catch-up of lost ticks also changes on that same tick whether the periodic limit is reached. The bench provokes this by enabling a matching alarm and a 16 Hz periodic rate together, then jumping the counter three intervals ahead. The first tick is judged to carry only the alarm flag, with two lost ticks. The second tick is judged to carry alarm and periodic together, two ticks earlier than plain counting would give.

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu #(
  parameter int CW = 32,
  parameter int TICK_DELTA = 256,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [5:0]    sec_i,
  input  logic [5:0]    min_i,
  input  logic [4:0]    hr_i,
  input  logic          upd_en,
  input  logic          alm_en,
  input  logic          per_en,
  input  logic [5:0]    alm_sec,
  input  logic [5:0]    alm_min,
  input  logic [4:0]    alm_hr,
  input  logic [3:0]    per_log2,
  output logic          irq,
  output logic [15:0]   flags,
  output logic [LW-1:0] lost
);
  localparam int BASE_LOG2 = 6;
  localparam int PCW = BASE_LOG2 + 1;
  localparam int SW = ((LW > PCW) ? LW : PCW) + 1;

  typedef enum logic [1:0] {IDLE, RUN, CATCH} st_t;

  st_t           st;
  logic [CW-1:0] cmp;
  logic          any_q, upd_q, sec_ok;
  logic [5:0]    prev_sec;
  logic [PCW-1:0] pie_cnt;
  logic [LW-1:0] lost_acc;

  wire any_en = upd_en | alm_en | per_en;
  wire fast = per_en && (per_log2 > 4'(BASE_LOG2));
  wire [3:0] sh = per_log2 - 4'(BASE_LOG2);
  wire [CW-1:0] step = fast ? (CW'(TICK_DELTA) >> sh) : CW'(TICK_DELTA);
  wire [PCW-1:0] limit = (per_log2 >= 4'(BASE_LOG2)) ? PCW'(1)
                         : (PCW'(1) << (4'(BASE_LOG2) - per_log2));

  wire [CW-1:0] diff = cnt_i - cmp;
  wire reached = !diff[CW-1];
  wire behind = reached && (diff != '0);
  wire eval = (st == CATCH) && !behind && any_en;

  wire [SW-1:0] pie_sum = SW'(pie_cnt) + SW'(lost_acc) + SW'(1);
  wire uf = upd_en && upd_q && sec_ok && (sec_i != prev_sec);
  wire af = alm_en && (sec_i == alm_sec) && (min_i == alm_min) && (hr_i == alm_hr);
  wire pf = per_en && (pie_sum >= SW'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      cmp      <= '0;
      any_q    <= 1'b0;
      upd_q    <= 1'b0;
      sec_ok   <= 1'b0;
      prev_sec <= '0;
      pie_cnt  <= '0;
      lost_acc <= '0;
      irq      <= 1'b0;
      flags    <= '0;
      lost     <= '0;
    end else begin
      any_q <= any_en;
      upd_q <= upd_en;
      irq   <= 1'b0;
      if (upd_en && !upd_q) sec_ok <= 1'b0;
      if (!any_en) begin
        st <= IDLE;
      end else begin
        case (st)
          IDLE: begin
            cmp <= cnt_i + step;
            st  <= RUN;
          end
          RUN: if (reached) begin
            cmp      <= cmp + step;
            lost_acc <= '0;
            st       <= CATCH;
          end
          default: begin
            if (behind) begin
              cmp      <= cmp + step;
              lost_acc <= (&lost_acc) ? lost_acc : lost_acc + 1'b1;
            end else begin
              st <= RUN;
            end
          end
        endcase
      end
      if (eval) begin
        if (upd_en) begin
          prev_sec <= sec_i;
          sec_ok   <= upd_q;
        end
        if (per_en) pie_cnt <= pf ? '0 : PCW'(pie_sum);
        if (uf || af || pf) begin
          irq   <= 1'b1;
          flags <= {8'h01, 1'b1, pf, af, uf, 4'b0000};
          lost  <= lost_acc;
        end
      end
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R13
  AST_FLAG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[15:8] == 8'h01 && flags[7] && (|flags[6:4]) && flags[3:0] == 4'h0)); // R9
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> !irq); // R10
  AST_PIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && flags[6]) |-> (pie_cnt == '0)); // R12
  AST_FIRST_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_en) |=> !(irq && flags[4])); // R11
endmodule

// File: tb/rtc_irq_emu_bench.sv
module rtc_irq_emu_bench;
  localparam int D = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cnt = 32'd1000;
  logic [31:0] jump = 32'd0;
  logic [5:0] sc = 6'd4, mn = 6'd2, a_sc = 6'd3, a_mn = 6'd2;
  logic [4:0] hr = 5'd1, a_hr = 5'd1;
  logic ue = 1'b0, ae = 1'b0, pe = 1'b0;
  logic [3:0] k = 4'd6;
  logic irq;
  logic [15:0] flags;
  logic [7:0] lost;
  int n_chk = 0, n_bad = 0, cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 32'd1 + jump;

  rtc_irq_emu #(.CW(32), .TICK_DELTA(D), .LW(8)) u_rtc_irq_emu (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .sec_i(sc), .min_i(mn), .hr_i(hr),
    .upd_en(ue), .alm_en(ae), .per_en(pe), .alm_sec(a_sc), .alm_min(a_mn),
    .alm_hr(a_hr), .per_log2(k), .irq(irq), .flags(flags), .lost(lost));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    ue = 0; ae = 0; pe = 0; k = 4'd6; jump = 0;
    hr = 5'd1; mn = 6'd2; sc = 6'd4; a_hr = 5'd1; a_mn = 6'd2; a_sc = 6'd3;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_irq(input int maxc, output int cyc);
    cyc = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (irq) begin
        cyc = i;
        break;
      end
    end
  endtask

  task automatic t_reset();
    restart();
    chk("R1 irq", irq, 0);
    chk("R1 flags", flags, 0);
    chk("R1 lost", lost, 0);
  endtask

  task automatic t_restart();
    int c;
    restart();
    sc = 6'd3; ae = 1;
    wait_irq(2 * D, c);
    chk("R2 first tick cycle", c, D + 2);
    chk("R4 R9 alarm flag word", flags, 16'h01A0);
    chk("R7 no lost", lost, 0);
    @(negedge clk);
    chk("R13 pulse low", irq, 0);
    chk("R13 flags held", flags, 16'h01A0);
    wait_irq(2 * D, c);
    chk("R2 tick spacing", c, D - 1);
  endtask

  task automatic t_alarm();
    int c;
    restart();
    sc = 6'd4; ae = 1;
    wait_irq(3 * D, c);
    chk("R4 no match no irq", c, -1);
    sc = 6'd3;
    wait_irq(D + 10, c);
    chk("R4 match raises", (c > 0) ? flags : -1, 16'h01A0);
  endtask

  task automatic t_update();
    int c;
    restart();
    sc = 6'd5; ue = 1;
    wait_irq(2 * D + 50, c);
    chk("R3 first tick silent", c, -1);
    sc = 6'd6;
    wait_irq(D + 10, c);
    chk("R3 seconds change", (c > 0) ? flags : -1, 16'h0190);
    wait_irq(D + 10, c);
    chk("R3 same seconds silent", c, -1);
    a_hr = 5'd20; ae = 1;
    @(negedge clk); ue = 0;
    @(negedge clk); sc = 6'd9; ue = 1;
    wait_irq(D + 10, c);
    chk("R11 re-enable invalidates", c, -1);
    sc = 6'd10;
    wait_irq(D + 10, c);
    chk("R11 later change raises", (c > 0) ? flags : -1, 16'h0190);
  endtask

  task automatic t_per_slow();
    int c;
    restart();
    k = 4'd4; pe = 1;
    wait_irq(6 * D, c);
    chk("R5 first periodic at 4th tick", c, 4 * D + 2);
    chk("R5 flag word", flags, 16'h01C0);
    wait_irq(6 * D, c);
    chk("R12 R5 periodic spacing", c, 4 * D);
  endtask

  task automatic t_per_fast();
    int c;
    restart();
    k = 4'd8; pe = 1;
    wait_irq(2 * D, c);
    chk("R6 first fast tick", c, D / 4 + 2);
    wait_irq(2 * D, c);
    chk("R6 fast spacing", c, D / 4);
  endtask

  task automatic t_lost();
    int c;
    restart();
    sc = 6'd3; k = 4'd4;
    ae = 1; pe = 1; jump = 3 * D + 10;
    @(negedge clk); jump = 0;
    wait_irq(2 * D, c);
    chk("R7 first tick flags", (c > 0) ? flags : -1, 16'h01A0);
    chk("R7 lost count", lost, 2);
    wait_irq(2 * D, c);
    chk("R8 periodic early with lost", (c > 0) ? flags : -1, 16'h01E0);
    chk("R7 no lost second tick", lost, 0);
  endtask

  task automatic t_disable();
    int c;
    restart();
    sc = 6'd3; ae = 1;
    wait_irq(2 * D, c);
    chk("R10 active before", (c > 0) ? 1 : 0, 1);
    ae = 0;
    wait_irq(3 * D, c);
    chk("R10 silent when all off", c, -1);
  endtask

  initial begin
    t_reset();
    t_restart();
    t_alarm();
    t_update();
    t_per_slow();
    t_per_fast();
    t_lost();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule